// File: doc/BRIEF.md
# Power-Up Protocol Selector with Answer-to-Reset

This block decides, once per power cycle, which serial protocol a secure-memory device speaks. It watches the external reset pin while the device clock runs after power-on. A pin that is high from the start selects the synchronous two-wire protocol. The pin is normally held high by an internal pull-up. A cold-reset sequence selects the asynchronous smart-card protocol: the pin is held low for a minimum number of clocks and then raised. After that the choice cannot be changed until power is removed.

In the asynchronous protocol the block waits a fixed delay and then sends the answer-to-reset. It shifts the bytes of a programmable 64-bit register onto the open-drain I/O line as framed characters. Each bit lasts one elementary time unit, which is a fixed number of card-clock periods. In the synchronous protocol the line is never driven. Instead, a ready flag rises once the required warm-up clock pulses have been seen. The command layers of both protocols sit downstream and take the mode output.

Top module: `proto_sel_atr`

## Requirements
- R1: While `por_n` is low, `mode_sel` is 2'b00, and `io_drive_low`, `atr_done` and `sync_ready` are all 0.
- R2: If `rst_pin` is high at the first rising clock edge after `por_n` is released, `mode_sel` becomes 2'b01 (synchronous) after that edge.
- R3: If `rst_pin` is low for at least LOW_MIN consecutive rising edges after power-on and is then sampled high, `mode_sel` becomes 2'b10 (asynchronous) after that edge.
- R4: If `rst_pin` is sampled high after fewer than LOW_MIN low edges (LOW_MIN-1 included), `mode_sel` becomes 2'b01.
- R5: Once `mode_sel` is non-zero it holds its value until `por_n` goes low; later activity on `rst_pin` has no effect on it.
- R6: In synchronous mode, `sync_ready` rises after the SYNC_WARMUP-th rising edge that follows the edge that selected the mode, and not before.
- R7: In synchronous mode, `io_drive_low` and `atr_done` stay 0.
- R8: In asynchronous mode, `io_drive_low` first goes high after edge E+ATR_DELAY, where E is the edge that selected the mode. It is 0 before that.
- R9: Each answer-to-reset character lasts 10+GUARD_ETUS time units of ETU_CLKS clocks each. It consists of a start bit (line low), eight data bits with the least significant bit first (a 0 bit drives the line low), and a parity bit that makes the count of ones in data plus parity even. `io_drive_low`=1 means the line is pulled low.
- R10: After the parity bit of each character the line is released for GUARD_ETUS time units. The characters are sent in the order `atr_reg[7:0]` first, then `atr_reg[15:8]`, and so on up to `atr_reg[63:56]`.
- R11: `atr_done` rises right after the last guard time unit of the eighth character. It then stays high with the line released until power-on reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Device clock; in asynchronous mode the card carrier clock |
| por_n | input | 1 | Power-on reset, active low, asynchronous |
| rst_pin | input | 1 | Level of the external reset pin |
| atr_reg | input | 64 | Answer-to-reset contents, byte 0 in bits 7:0 |
| mode_sel | output | 2 | 00 undecided, 01 synchronous two-wire, 10 asynchronous |
| sync_ready | output | 1 | Synchronous warm-up pulses received |
| io_drive_low | output | 1 | Pull the open-drain I/O line low |
| atr_done | output | 1 | Answer-to-reset fully sent |

## Verification
The bench builds the block with LOW_MIN=40, ATR_DELAY=24, ETU_CLKS=16, GUARD_ETUS=2 and SYNC_WARMUP=5. With these values one full cold-reset sequence and answer-to-reset takes about 1,600 clocks. That leaves room to power-cycle the block for several register patterns and to test the LOW_MIN-1 threshold exactly. The short time unit also lets the bench sample the middle of every one of the 96 bit slots and check the exact start and end edges of the transmission.

// File: rtl/proto_sel_pkg.sv
package proto_sel_pkg;
   typedef enum logic [1:0] {
      MODE_NONE  = 2'b00,
      MODE_SYNC  = 2'b01,
      MODE_ASYNC = 2'b10
   } proto_mode_e;

   typedef enum logic [1:0] {
      TX_IDLE = 2'b00,
      TX_WAIT = 2'b01,
      TX_SEND = 2'b10,
      TX_FIN  = 2'b11
   } tx_state_e;

   localparam int FRAME_BITS = 10;
endpackage

// File: rtl/proto_decider.sv
module proto_decider
   import proto_sel_pkg::*;
#(
   parameter int LOW_MIN = 400
) (
   input  logic        clk,
   input  logic        por_n,
   input  logic        rst_pin,
   output proto_mode_e mode,
   output logic        cold_start
);
   localparam int CW = $clog2(LOW_MIN + 1);
   localparam logic [CW-1:0] LOW_LIM = CW'(LOW_MIN);

   if (LOW_MIN < 1) begin : g_bad_low
      $error("LOW_MIN must be at least 1");
   end

   logic [CW-1:0] low_cnt;

   always_ff @(posedge clk or negedge por_n) begin
      if (!por_n) begin
         mode       <= MODE_NONE;
         low_cnt    <= '0;
         cold_start <= 1'b0;
      end else begin
         cold_start <= 1'b0;
         if (mode == MODE_NONE) begin
            if (rst_pin) begin
               if (low_cnt >= LOW_LIM) begin
                  mode       <= MODE_ASYNC;
                  cold_start <= 1'b1;
               end else begin
                  mode <= MODE_SYNC;
               end
            end else if (low_cnt < LOW_LIM) begin
               low_cnt <= low_cnt + 1'b1;
            end
         end
      end
   end

   assert_mode_locked_R5: assert property (@(posedge clk) disable iff (!por_n)
      (mode != MODE_NONE) |=> (mode == $past(mode)));

   assert_async_needs_high_R3: assert property (@(posedge clk) disable iff (!por_n)
      (mode == MODE_NONE && !rst_pin) |=> (mode == MODE_NONE));
endmodule

// File: rtl/sync_warmup.sv
module sync_warmup #(
   parameter int SYNC_WARMUP = 5
) (
   input  logic clk,
   input  logic por_n,
   input  logic enable,
   output logic ready
);
   localparam int WW = $clog2(SYNC_WARMUP + 1);
   localparam logic [WW-1:0] WARM_LIM = WW'(SYNC_WARMUP);

   if (SYNC_WARMUP < 1) begin : g_bad_warm
      $error("SYNC_WARMUP must be at least 1");
   end

   logic [WW-1:0] pulse_cnt;

   always_ff @(posedge clk or negedge por_n) begin
      if (!por_n) begin
         pulse_cnt <= '0;
      end else if (enable && pulse_cnt < WARM_LIM) begin
         pulse_cnt <= pulse_cnt + 1'b1;
      end
   end

   assign ready = (pulse_cnt == WARM_LIM);

   assert_ready_in_sync_R6: assert property (@(posedge clk) disable iff (!por_n)
      ready |-> enable);
endmodule

// File: rtl/atr_serializer.sv
module atr_serializer
   import proto_sel_pkg::*;
#(
   parameter int ETU_CLKS   = 372,
   parameter int ATR_BYTES  = 8,
   parameter int GUARD_ETUS = 2,
   parameter int ATR_DELAY  = 400
) (
   input  logic                   clk,
   input  logic                   por_n,
   input  logic                   start,
   input  logic [ATR_BYTES*8-1:0] atr_bits,
   output logic                   io_low,
   output logic                   done
);
   localparam int SLOTS = FRAME_BITS + GUARD_ETUS;
   localparam int EW    = $clog2(ETU_CLKS);
   localparam int SW    = $clog2(SLOTS);
   localparam int BW    = (ATR_BYTES > 1) ? $clog2(ATR_BYTES) : 1;
   localparam int DW    = $clog2(ATR_DELAY);
   localparam logic [EW-1:0] ETU_LAST  = EW'(ETU_CLKS - 1);
   localparam logic [SW-1:0] SLOT_LAST = SW'(SLOTS - 1);
   localparam logic [BW-1:0] BYTE_LAST = BW'(ATR_BYTES - 1);
   localparam logic [DW-1:0] WAIT_LAST = DW'(ATR_DELAY - 1);

   if (ETU_CLKS < 2) begin : g_bad_etu
      $error("ETU_CLKS must be at least 2");
   end
   if (ATR_DELAY < 2) begin : g_bad_delay
      $error("ATR_DELAY must be at least 2");
   end
   if (GUARD_ETUS < 2) begin : g_bad_guard
      $error("GUARD_ETUS must be at least 2");
   end
   if (ATR_BYTES < 1) begin : g_bad_bytes
      $error("ATR_BYTES must be at least 1");
   end

   tx_state_e     state;
   logic [DW-1:0] wait_cnt;
   logic [EW-1:0] etu_cnt;
   logic [SW-1:0] slot;
   logic [BW-1:0] byte_idx;

   always_ff @(posedge clk or negedge por_n) begin
      if (!por_n) begin
         state    <= TX_IDLE;
         wait_cnt <= '0;
         etu_cnt  <= '0;
         slot     <= '0;
         byte_idx <= '0;
      end else begin
         unique case (state)
            TX_IDLE: begin
               if (start) begin
                  state    <= TX_WAIT;
                  wait_cnt <= DW'(1);
               end
            end
            TX_WAIT: begin
               if (wait_cnt == WAIT_LAST) begin
                  state    <= TX_SEND;
                  etu_cnt  <= '0;
                  slot     <= '0;
                  byte_idx <= '0;
               end else begin
                  wait_cnt <= wait_cnt + 1'b1;
               end
            end
            TX_SEND: begin
               if (etu_cnt == ETU_LAST) begin
                  etu_cnt <= '0;
                  if (slot == SLOT_LAST) begin
                     slot <= '0;
                     if (byte_idx == BYTE_LAST) begin
                        state <= TX_FIN;
                     end else begin
                        byte_idx <= byte_idx + 1'b1;
                     end
                  end else begin
                     slot <= slot + 1'b1;
                  end
               end else begin
                  etu_cnt <= etu_cnt + 1'b1;
               end
            end
            default: state <= TX_FIN;
         endcase
      end
   end

   logic [7:0]    cur_byte;
   logic [SW-1:0] data_pos;
   logic          line_level;

   always_comb begin
      cur_byte = atr_bits[{byte_idx, 3'b000} +: 8];
      data_pos = slot - SW'(1);
      if (slot == '0) begin
         line_level = 1'b0;
      end else if (slot <= SW'(8)) begin
         line_level = cur_byte[data_pos[2:0]];
      end else if (slot == SW'(9)) begin
         line_level = ^cur_byte;
      end else begin
         line_level = 1'b1;
      end
   end

   assign io_low = (state == TX_SEND) && !line_level;
   assign done   = (state == TX_FIN);

   assert_quiet_before_atr_R8: assert property (@(posedge clk) disable iff (!por_n)
      start |=> !io_low);

   assert_done_sticky_R11: assert property (@(posedge clk) disable iff (!por_n)
      done |=> done);

   assert_done_released_R11: assert property (@(posedge clk) disable iff (!por_n)
      done |-> !io_low);
endmodule

// File: rtl/proto_sel_atr.sv
module proto_sel_atr
   import proto_sel_pkg::*;
#(
   parameter int LOW_MIN     = 400,
   parameter int ATR_DELAY   = 400,
   parameter int ETU_CLKS    = 372,
   parameter int GUARD_ETUS  = 2,
   parameter int SYNC_WARMUP = 5,
   parameter int ATR_BYTES   = 8
) (
   input  logic                   clk,
   input  logic                   por_n,
   input  logic                   rst_pin,
   input  logic [ATR_BYTES*8-1:0] atr_reg,
   output logic [1:0]             mode_sel,
   output logic                   sync_ready,
   output logic                   io_drive_low,
   output logic                   atr_done
);
   proto_mode_e mode;
   logic        cold_start;

   proto_decider #(.LOW_MIN(LOW_MIN)) decider_i (
      .clk        (clk),
      .por_n      (por_n),
      .rst_pin    (rst_pin),
      .mode       (mode),
      .cold_start (cold_start)
   );

   sync_warmup #(.SYNC_WARMUP(SYNC_WARMUP)) warmup_i (
      .clk    (clk),
      .por_n  (por_n),
      .enable (mode == MODE_SYNC),
      .ready  (sync_ready)
   );

   atr_serializer #(
      .ETU_CLKS   (ETU_CLKS),
      .ATR_BYTES  (ATR_BYTES),
      .GUARD_ETUS (GUARD_ETUS),
      .ATR_DELAY  (ATR_DELAY)
   ) tx_i (
      .clk      (clk),
      .por_n    (por_n),
      .start    (cold_start),
      .atr_bits (atr_reg),
      .io_low   (io_drive_low),
      .done     (atr_done)
   );

   assign mode_sel = mode;

   assert_sync_silent_R7: assert property (@(posedge clk) disable iff (!por_n)
      (mode == MODE_SYNC) |-> (!io_drive_low && !atr_done));

   assert_reset_state_R1: assert property (@(posedge clk)
      !por_n |-> (mode_sel == 2'b00 && !io_drive_low && !atr_done && !sync_ready));
endmodule

// File: tb/proto_sel_atr_tb_top.sv
module proto_sel_atr_tb_top;
   localparam int LOW_MIN = 40;
   localparam int ATR_DELAY = 24;
   localparam int ETU = 16;
   localparam int GUARD = 2;
   localparam int WARM = 5;
   localparam int NB = 8;
   localparam int SLOTS = 10 + GUARD;
   localparam int NVEC = 3;
   localparam logic [63:0] ATR_VEC [NVEC] = '{
      64'h3B02_14A5_9C6E_0F81,
      64'h0000_0000_0000_0000,
      64'hFFFF_FFFF_FFFF_FFFF
   };

   logic clk = 1'b0;
   always #2 clk = ~clk;

   logic        por_n;
   logic        rst_pin;
   logic [63:0] atr_reg;
   logic [1:0]  mode_sel;
   logic        sync_ready, io_drive_low, atr_done;

   proto_sel_atr #(
      .LOW_MIN(LOW_MIN), .ATR_DELAY(ATR_DELAY), .ETU_CLKS(ETU),
      .GUARD_ETUS(GUARD), .SYNC_WARMUP(WARM), .ATR_BYTES(NB)
   ) dut_i (
      .clk(clk), .por_n(por_n), .rst_pin(rst_pin), .atr_reg(atr_reg),
      .mode_sel(mode_sel), .sync_ready(sync_ready),
      .io_drive_low(io_drive_low), .atr_done(atr_done)
   );

   int checks = 0;
   int fails = 0;
   int cur = 0;
   bit finished = 0;

   task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic finish_run();
      if (!finished) begin
         finished = 1;
         $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   endtask

   task automatic adv(input int tgt);
      while (cur < tgt) begin
         @(negedge clk);
         cur++;
      end
   endtask

   task automatic power_on(input bit lvl);
      @(negedge clk);
      por_n = 1'b0;
      rst_pin = lvl;
      repeat (3) @(negedge clk);
      por_n = 1'b1;
   endtask

   function automatic logic [11:0] frame_of(input logic [7:0] b);
      logic [11:0] f;
      f[0] = 1'b0;
      f[8:1] = b;
      f[9] = ^b;
      f[11:10] = 2'b11;
      return f;
   endfunction

   task automatic async_atr(input logic [63:0] v);
      logic [11:0] got;
      atr_reg = v;
      power_on(1'b0);
      repeat (LOW_MIN) @(negedge clk);
      rst_pin = 1'b1;
      @(negedge clk);
      cur = 0;
      chk(mode_sel == 2'b10, "R3 async select", 64'(mode_sel), 64'h2);
      adv(ATR_DELAY - 1);
      chk(io_drive_low == 1'b0, "R8 quiet before delay", 64'(io_drive_low), 64'h0);
      adv(ATR_DELAY);
      chk(io_drive_low == 1'b1, "R8 start bit at delay", 64'(io_drive_low), 64'h1);
      for (int b = 0; b < NB; b++) begin
         for (int s = 0; s < SLOTS; s++) begin
            adv(ATR_DELAY + (b * SLOTS + s) * ETU + ETU / 2);
            got[s] = ~io_drive_low;
         end
         chk(got == frame_of(v[b*8 +: 8]), "R9 R10 character frame", 64'(got), 64'(frame_of(v[b*8 +: 8])));
      end
      adv(ATR_DELAY + NB * SLOTS * ETU - 1);
      chk(atr_done == 1'b0, "R11 done not early", 64'(atr_done), 64'h0);
      adv(ATR_DELAY + NB * SLOTS * ETU);
      chk(atr_done == 1'b1 && io_drive_low == 1'b0, "R11 done and released",
          {62'h0, atr_done, io_drive_low}, 64'h2);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      fails++;
      $display("FAIL watchdog expired");
      finish_run();
   end

   initial begin
      bit quiet;
      por_n = 1'b0;
      rst_pin = 1'b1;
      atr_reg = '0;
      repeat (2) @(negedge clk);
      chk(mode_sel == 2'b00 && !io_drive_low && !atr_done && !sync_ready, "R1 reset state",
          {59'h0, mode_sel, io_drive_low, atr_done, sync_ready}, 64'h0);

      for (int i = 0; i < NVEC; i++) begin
         async_atr(ATR_VEC[i]);
      end

      // R5: RST activity after the ATR is ignored
      rst_pin = 1'b0;
      repeat (50) @(negedge clk);
      rst_pin = 1'b1;
      repeat (5) @(negedge clk);
      chk(mode_sel == 2'b10 && atr_done && !io_drive_low, "R5 async locked",
          {61'h0, mode_sel, atr_done}, 64'h5);

      // R1: reset asserted mid-run
      por_n = 1'b0;
      @(negedge clk);
      chk(mode_sel == 2'b00 && !io_drive_low && !atr_done && !sync_ready, "R1 reset clears",
          {59'h0, mode_sel, io_drive_low, atr_done, sync_ready}, 64'h0);

      // R2 / R6: synchronous default
      power_on(1'b1);
      @(negedge clk);
      cur = 0;
      chk(mode_sel == 2'b01, "R2 sync select", 64'(mode_sel), 64'h1);
      adv(WARM - 1);
      chk(sync_ready == 1'b0, "R6 ready not early", 64'(sync_ready), 64'h0);
      adv(WARM);
      chk(sync_ready == 1'b1, "R6 ready after warm-up", 64'(sync_ready), 64'h1);

      // R5 / R7: a full cold-reset pattern in sync mode changes nothing
      quiet = 1;
      rst_pin = 1'b0;
      for (int k = 0; k < LOW_MIN + 10; k++) begin
         @(negedge clk);
         if (io_drive_low || atr_done) quiet = 0;
      end
      rst_pin = 1'b1;
      for (int k = 0; k < ATR_DELAY + 3 * ETU; k++) begin
         @(negedge clk);
         if (io_drive_low || atr_done) quiet = 0;
      end
      chk(quiet, "R7 sync line never driven", 64'(quiet), 64'h1);
      chk(mode_sel == 2'b01, "R5 sync locked", 64'(mode_sel), 64'h1);

      // R4: early rise
      power_on(1'b0);
      repeat (10) @(negedge clk);
      rst_pin = 1'b1;
      @(negedge clk);
      chk(mode_sel == 2'b01, "R4 early rise selects sync", 64'(mode_sel), 64'h1);

      // R4: one clock short of the threshold
      power_on(1'b0);
      repeat (LOW_MIN - 1) @(negedge clk);
      rst_pin = 1'b1;
      @(negedge clk);
      chk(mode_sel == 2'b01, "R4 threshold minus one", 64'(mode_sel), 64'h1);

      finish_run();
   end
endmodule